// File: doc/BRIEF.md
# Processor Presence Map with Hot-Plug Event

This block keeps one presence bit per processor identifier. It has 256 bits by default, grouped into 32 bytes. Software reads the map one byte at a time over a small request/response window. Byte `a`, bit `j`, holds the presence of processor `8*a + j`.

Hot-plug logic reports arrivals and departures on two request streams, one for plug and one for unplug. Each stream carries a 9-bit identifier, so out-of-range values can be expressed and rejected. Every accepted request also raises a sticky bit in a small general-purpose event status register. Software clears that bit by writing a one to its position.

The presence of the processors that exist at power-up comes from an initial vector. That vector is sampled while reset is held, and it raises no event. Software writes into the map window complete their handshake but change nothing.

All three request interfaces use valid/ready. Each ready is tied high: the block never applies back-pressure, and a request is consumed in every cycle its valid is high. A read returns its byte on `rsp_valid`/`rsp_data` in the cycle after the request. There is no ready on the response side, so the consumer must take it.

Top module: `cpu_presence_map`

## Requirements
- R1: While `rst_n` is low, the map loads `init_present`. After reset, `gpe_sts` is 0, `id_err` is 0 and `rsp_valid` is 0, and the initially present processors raise no event.
- R2: A read (`sw_valid`=1, `sw_we`=0, `sw_addr`=a) gives `rsp_valid`=1 in the next cycle. `rsp_data` then holds byte a, whose bit j is the presence of identifier 8a+j. The read sees the map as it was before any update at the same clock edge. Without a read, `rsp_valid` is 0.
- R3: An accepted plug request sets the presence bit of its identifier from the next cycle on.
- R4: An accepted unplug request clears the presence bit of its identifier from the next cycle on.
- R5: Any accepted plug or unplug request sets `gpe_sts` bit 2 (value 0x04) in the next cycle. The other status bits are never set.
- R6: A write (`sw_valid`=1, `sw_we`=1) changes neither the map nor any other output, and produces no response.
- R7: `gpe_sts` bit 2 stays set until a clear (`evt_clr_valid`=1 with `evt_clr_mask` bit 2 = 1). A clear whose mask has bit 2 = 0 has no effect on it. A new event in the same cycle as a clear leaves the bit set.
- R8: An identifier of 256 or more is rejected: the map and `gpe_sts` do not change, and `id_err` is 1 in the next cycle, 0 otherwise.
- R9: If a plug and an unplug name the same identifier in the same cycle, the bit ends set. If they name different identifiers, both take effect.
- R10: `plug_ready`, `unplug_ready` and `sw_ready` are always 1 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the map loads `init_present` while it is low |
| init_present | input | 256 | Presence of processors at power-up |
| plug_valid | input | 1 | Plug request valid |
| plug_id | input | 9 | Identifier being plugged |
| plug_ready | output | 1 | Plug request ready (always 1) |
| unplug_valid | input | 1 | Unplug request valid |
| unplug_id | input | 9 | Identifier being removed |
| unplug_ready | output | 1 | Unplug request ready (always 1) |
| sw_valid | input | 1 | Software window access valid |
| sw_ready | output | 1 | Software window ready (always 1) |
| sw_we | input | 1 | 1 = write (ignored), 0 = read |
| sw_addr | input | 5 | Byte offset in the window |
| sw_wdata | input | 8 | Write data (discarded) |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 8 | Read response byte |
| evt_clr_valid | input | 1 | Event status clear strobe |
| evt_clr_mask | input | 8 | Write-one-to-clear mask for `gpe_sts` |
| gpe_sts | output | 8 | Event status; bit 2 is the processor hot-plug event |
| id_err | output | 1 | Pulses for one cycle after an out-of-range identifier |

## Verification
The hardest situations to reach from the ports are those where several things meet at one clock edge:
- a plug and an unplug naming the same identifier;
- a read of a byte that is being modified in that same cycle;
- an event that collides with its own clear.

The stimulus drives all of these on a single cycle through one driver task that accepts every input at once. It then reads the affected bytes back through the scoreboard. A long pseudo-random phase mixes valid and out-of-range identifiers, including 255 and 256. A full 32-byte sweep afterwards compares the whole map against the bench's own bit model.

// File: rtl/cpumap_pkg.sv
package cpumap_pkg;

  localparam int BYTE_W = 8;

  // Outcome of range-checking one incoming request
  typedef struct packed {
    logic ok;
    logic bad;
  } req_chk_t;

endpackage

// File: rtl/cpumap_req_check.sv
module cpumap_req_check
  import cpumap_pkg::*;
#(
  parameter int NUM_CPUS = 256,
  parameter int IDX_W    = $clog2(NUM_CPUS),
  parameter int ID_W     = IDX_W + 1
) (
  input  logic                plug_valid_i,
  input  logic [ID_W-1:0]     plug_id_i,
  input  logic                unplug_valid_i,
  input  logic [ID_W-1:0]     unplug_id_i,
  output logic [NUM_CPUS-1:0] set_vec_o,
  output logic [NUM_CPUS-1:0] clr_vec_o,
  output logic                any_ok_o,
  output logic                any_bad_o
);

  localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(NUM_CPUS);

  function automatic req_chk_t classify(input logic v, input logic [ID_W-1:0] id);
    req_chk_t r;
    r.ok  = v && (id < ID_LIMIT);
    r.bad = v && !(id < ID_LIMIT);
    return r;
  endfunction

  req_chk_t            plug_c, unplug_c;
  logic [NUM_CPUS-1:0] clr_raw;

  always_comb begin
    plug_c   = classify(plug_valid_i, plug_id_i);
    unplug_c = classify(unplug_valid_i, unplug_id_i);
  end

  // One-hot decode; a plug masks an unplug of the same bit
  always_comb begin
    set_vec_o = '0;
    clr_raw   = '0;
    if (plug_c.ok)   set_vec_o[plug_id_i[IDX_W-1:0]]   = 1'b1;
    if (unplug_c.ok) clr_raw[unplug_id_i[IDX_W-1:0]]   = 1'b1;
    clr_vec_o = clr_raw & ~set_vec_o;
  end

  assign any_ok_o  = plug_c.ok  | unplug_c.ok;
  assign any_bad_o = plug_c.bad | unplug_c.bad;

endmodule

// File: rtl/cpumap_bits.sv
module cpumap_bits
  import cpumap_pkg::*;
#(
  parameter int NUM_CPUS = 256,
  parameter int BYTES    = NUM_CPUS / BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CPUS-1:0] init_vec_i,
  input  logic [NUM_CPUS-1:0] set_vec_i,
  input  logic [NUM_CPUS-1:0] clr_vec_i,
  output logic [NUM_CPUS-1:0] map_o
);

  logic [NUM_CPUS-1:0] map_q;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    localparam int LO = b * BYTE_W;
    always_ff @(posedge clk) begin
      if (!rst_n)
        map_q[LO +: BYTE_W] <= init_vec_i[LO +: BYTE_W];
      else
        map_q[LO +: BYTE_W] <= (map_q[LO +: BYTE_W] & ~clr_vec_i[LO +: BYTE_W])
                               | set_vec_i[LO +: BYTE_W];
    end
  end

  assign map_o = map_q;

  p_set_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec_i != '0) |=> ((map_q & $past(set_vec_i)) == $past(set_vec_i)));

  p_clr_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec_i != '0) |=> ((map_q & $past(clr_vec_i)) == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec_i == '0 && clr_vec_i == '0) |=> $stable(map_q));

endmodule

// File: rtl/cpumap_sts.sv
module cpumap_sts #(
  parameter int GPE_W   = 8,
  parameter int EVT_BIT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_set_i,
  input  logic             clr_valid_i,
  input  logic [GPE_W-1:0] clr_mask_i,
  output logic [GPE_W-1:0] sts_o
);

  logic [GPE_W-1:0] sts_q;

  for (genvar i = 0; i < GPE_W; i++) begin : g_bit
    logic src;
    if (i == EVT_BIT) begin : g_evt
      assign src = evt_set_i;
    end else begin : g_none
      assign src = 1'b0;
    end
    // Set has priority over a simultaneous write-one-to-clear
    always_ff @(posedge clk) begin
      if (!rst_n)
        sts_q[i] <= 1'b0;
      else if (src)
        sts_q[i] <= 1'b1;
      else if (clr_valid_i && clr_mask_i[i])
        sts_q[i] <= 1'b0;
    end
  end

  assign sts_o = sts_q;

  p_evt_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set_i |=> sts_q[EVT_BIT]);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[EVT_BIT] && !(clr_valid_i && clr_mask_i[EVT_BIT])) |=> sts_q[EVT_BIT]);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid_i && clr_mask_i[EVT_BIT] && !evt_set_i) |=> !sts_q[EVT_BIT]);

endmodule

// File: rtl/cpumap_rd.sv
module cpumap_rd
  import cpumap_pkg::*;
#(
  parameter int NUM_CPUS = 256,
  parameter int BYTES    = NUM_CPUS / BYTE_W,
  parameter int ADDR_W   = $clog2(BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_CPUS-1:0] map_i,
  output logic                rsp_valid_o,
  output logic [BYTE_W-1:0]   rsp_data_o
);

  logic [BYTE_W-1:0] lanes [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign lanes[b] = map_i[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= rd_en_i;
      if (rd_en_i) rsp_data_o <= lanes[addr_i];
    end
  end

  p_rsp_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rsp_valid_o);

  p_no_rsp_without_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rsp_valid_o);

endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map
  import cpumap_pkg::*;
#(
  parameter int NUM_CPUS = 256,
  parameter int GPE_W    = 8,
  parameter int EVT_BIT  = 2,
  parameter int IDX_W    = $clog2(NUM_CPUS),
  parameter int ID_W     = IDX_W + 1,
  parameter int BYTES    = NUM_CPUS / BYTE_W,
  parameter int ADDR_W   = $clog2(BYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CPUS-1:0] init_present,
  input  logic                plug_valid,
  input  logic [ID_W-1:0]     plug_id,
  output logic                plug_ready,
  input  logic                unplug_valid,
  input  logic [ID_W-1:0]     unplug_id,
  output logic                unplug_ready,
  input  logic                sw_valid,
  output logic                sw_ready,
  input  logic                sw_we,
  input  logic [ADDR_W-1:0]   sw_addr,
  input  logic [BYTE_W-1:0]   sw_wdata,
  output logic                rsp_valid,
  output logic [BYTE_W-1:0]   rsp_data,
  input  logic                evt_clr_valid,
  input  logic [GPE_W-1:0]    evt_clr_mask,
  output logic [GPE_W-1:0]    gpe_sts,
  output logic                id_err
);

  logic [NUM_CPUS-1:0] set_vec, clr_vec, map_w;
  logic                any_ok, any_bad, id_err_q;

  assign plug_ready   = 1'b1;
  assign unplug_ready = 1'b1;
  assign sw_ready     = 1'b1;

  cpumap_req_check #(.NUM_CPUS(NUM_CPUS), .IDX_W(IDX_W), .ID_W(ID_W)) u_check (
    .plug_valid_i   (plug_valid),
    .plug_id_i      (plug_id),
    .unplug_valid_i (unplug_valid),
    .unplug_id_i    (unplug_id),
    .set_vec_o      (set_vec),
    .clr_vec_o      (clr_vec),
    .any_ok_o       (any_ok),
    .any_bad_o      (any_bad)
  );

  cpumap_bits #(.NUM_CPUS(NUM_CPUS), .BYTES(BYTES)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_vec_i (init_present),
    .set_vec_i  (set_vec),
    .clr_vec_i  (clr_vec),
    .map_o      (map_w)
  );

  cpumap_rd #(.NUM_CPUS(NUM_CPUS), .BYTES(BYTES), .ADDR_W(ADDR_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en_i     (sw_valid && !sw_we),
    .addr_i      (sw_addr),
    .map_i       (map_w),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data)
  );

  cpumap_sts #(.GPE_W(GPE_W), .EVT_BIT(EVT_BIT)) u_sts (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_set_i   (any_ok),
    .clr_valid_i (evt_clr_valid),
    .clr_mask_i  (evt_clr_mask),
    .sts_o       (gpe_sts)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) id_err_q <= 1'b0;
    else        id_err_q <= any_bad;
  end
  assign id_err = id_err_q;

  p_bad_plug_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (plug_valid && plug_id >= ID_W'(NUM_CPUS)) |=> id_err);

  p_bad_only_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (plug_valid && plug_id >= ID_W'(NUM_CPUS) && !unplug_valid) |=> $stable(map_w));

  p_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_valid && sw_we && sw_wdata != '0 && !plug_valid && !unplug_valid) |=> $stable(map_w));

  p_same_id_plug_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (plug_valid && unplug_valid && plug_id == unplug_id && plug_id < ID_W'(NUM_CPUS))
    |=> map_w[$past(plug_id[IDX_W-1:0])]);

endmodule

// File: tb/cpu_presence_map_tb.sv
`timescale 1ns/1ps
module cpu_presence_map_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [255:0] init_present;
  logic         plug_valid, unplug_valid, sw_valid, sw_we, evt_clr_valid;
  logic [8:0]   plug_id, unplug_id;
  logic [4:0]   sw_addr;
  logic [7:0]   sw_wdata, evt_clr_mask;
  logic         plug_ready, unplug_ready, sw_ready, rsp_valid, id_err;
  logic [7:0]   rsp_data, gpe_sts;

  always #2.5 clk = ~clk;

  cpu_presence_map dut_i (
    .clk(clk), .rst_n(rst_n), .init_present(init_present),
    .plug_valid(plug_valid), .plug_id(plug_id), .plug_ready(plug_ready),
    .unplug_valid(unplug_valid), .unplug_id(unplug_id), .unplug_ready(unplug_ready),
    .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_we(sw_we), .sw_addr(sw_addr),
    .sw_wdata(sw_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .evt_clr_valid(evt_clr_valid), .evt_clr_mask(evt_clr_mask),
    .gpe_sts(gpe_sts), .id_err(id_err)
  );

  int           checks = 0;
  int           errors = 0;
  bit           done = 0;
  logic [255:0] model;
  logic [7:0]   exp_sts;
  logic [7:0]   sb_data [$];
  string        sb_tag [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a response appears
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid) begin
      if (sb_data.size() == 0) begin
        chk(1'b0, "R6", "response without read", {24'h0, rsp_data}, 32'h0);
      end else begin
        logic [7:0] e;
        string      t;
        e = sb_data.pop_front();
        t = sb_tag.pop_front();
        chk(rsp_data == e, t, "read byte", {24'h0, rsp_data}, {24'h0, e});
      end
    end
  end

  // Driver: one request cycle, then checks of the registered status
  task automatic cyc(input bit pv, input logic [8:0] pid, input bit uv, input logic [8:0] uid,
                     input bit sv, input bit swe, input logic [4:0] a, input logic [7:0] wd,
                     input bit cv, input logic [7:0] cm, input string tag);
    bit pok, uok, eerr;
    @(negedge clk);
    plug_valid = pv; plug_id = pid; unplug_valid = uv; unplug_id = uid;
    sw_valid = sv; sw_we = swe; sw_addr = a; sw_wdata = wd;
    evt_clr_valid = cv; evt_clr_mask = cm;
    if (sv && !swe) begin
      sb_data.push_back(model[a*8 +: 8]);
      sb_tag.push_back(tag);
    end
    pok  = pv && (pid < 9'd256);
    uok  = uv && (uid < 9'd256);
    eerr = (pv && !pok) || (uv && !uok);
    if (uok) model[uid[7:0]] = 1'b0;
    if (pok) model[pid[7:0]] = 1'b1;
    if (cv) exp_sts = exp_sts & ~cm;
    if (pok || uok) exp_sts[2] = 1'b1;
    @(negedge clk);
    plug_valid = 0; unplug_valid = 0; sw_valid = 0; evt_clr_valid = 0;
    chk(gpe_sts == exp_sts, (cv ? "R7" : "R5"), "gpe_sts", {24'h0, gpe_sts}, {24'h0, exp_sts});
    chk(id_err == eerr, "R8", "id_err", {31'h0, id_err}, {31'h0, eerr});
    if (sv && swe)
      chk(rsp_valid == 1'b0, "R6", "write gave response", {31'h0, rsp_valid}, 32'h0);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    cyc(0, 0, 0, 0, 1, 0, a, 0, 0, 0, tag);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 32; a++) rd(a[4:0], tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) init_present[i] = (i % 7 == 0) || (i % 13 == 1);
    model = init_present;
    exp_sts = 8'h00;
    rst_n = 0;
    plug_valid = 0; unplug_valid = 0; sw_valid = 0; sw_we = 0; evt_clr_valid = 0;
    plug_id = 0; unplug_id = 0; sw_addr = 0; sw_wdata = 0; evt_clr_mask = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(gpe_sts == 8'h00, "R1", "gpe_sts after reset", {24'h0, gpe_sts}, 32'h0);
    chk(id_err == 1'b0, "R1", "id_err after reset", {31'h0, id_err}, 32'h0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    chk(plug_ready && unplug_ready && sw_ready, "R10", "ready low",
        {29'h0, plug_ready, unplug_ready, sw_ready}, 32'h7);
    read_all("R1");

    // R3: plug, then observe byte 0 and event
    cyc(1, 9'd3, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    rd(5'd0, "R3");
    // R7: clear with mask lacking bit 2 has no effect, then a real clear
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hFB, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h04, "R7");
    // R4: unplug an initially present id
    cyc(0, 0, 1, 9'd0, 0, 0, 0, 0, 0, 0, "R4");
    rd(5'd0, "R4");
    // R3: highest valid id
    cyc(1, 9'd255, 0, 0, 0, 0, 0, 0, 1, 8'h04, "R3");
    rd(5'd31, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hFF, "R7");
    // R9: same id both ways, then different ids
    cyc(1, 9'd100, 1, 9'd100, 0, 0, 0, 0, 0, 0, "R9");
    rd(5'd12, "R9");
    cyc(1, 9'd10, 1, 9'd14, 0, 0, 0, 0, 0, 0, "R9");
    rd(5'd1, "R9");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h04, "R7");
    // R8: out-of-range identifiers change nothing but raise id_err
    cyc(1, 9'd256, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 1, 9'd300, 0, 0, 0, 0, 0, 0, "R8");
    cyc(1, 9'd511, 1, 9'd256, 0, 0, 0, 0, 0, 0, "R8");
    rd(5'd0, "R8");
    rd(5'd31, "R8");
    // R6: write to the window, then read back unchanged
    cyc(0, 0, 0, 0, 1, 1, 5'd3, 8'hFF, 0, 0, "R6");
    cyc(0, 0, 0, 0, 1, 1, 5'd12, 8'h00, 0, 0, "R6");
    rd(5'd3, "R6");
    rd(5'd12, "R6");
    // R2: read in the same cycle as a plug of that byte sees the old value
    cyc(1, 9'd17, 0, 0, 1, 0, 5'd2, 0, 0, 0, "R2");
    rd(5'd2, "R2");
    // R7: event collides with its own clear; bit stays set
    cyc(1, 9'd40, 0, 0, 0, 0, 0, 0, 1, 8'h04, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h04, "R7");
    // Mixed pseudo-random traffic
    for (int k = 0; k < 400; k++) begin
      logic [8:0] p, u;
      p = 9'($urandom_range(0, 300));
      u = 9'($urandom_range(0, 300));
      cyc($urandom_range(0, 1) == 1, p, $urandom_range(0, 1) == 1, u,
          $urandom_range(0, 3) == 0, 0, 5'($urandom_range(0, 31)), 0,
          $urandom_range(0, 4) == 0, 8'h04, "R4");
    end
    read_all("R3");
    repeat (3) @(negedge clk);
    chk(sb_data.size() == 0, "R2", "responses missing", sb_data.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule